// File: doc/BRIEF.md
# Quadratic-Extension Field Multiplier Sequencer

This block holds up to 128 elements of the field GF(p^2), where p = 2^127 - 1. Each element is a pair of 127-bit base-field residues, and the block multiplies two stored elements in place. A command names two source elements and one destination element. The sequencer reads the four source words through the two ports of its internal dual-port RAM. It forms the two operand sums, streams three base-field products back to back through a pipelined Mersenne multiplier, finishes with three modular subtractions and writes both halves of the result in one cycle.

The product of x = (x0, x1) and y = (y0, y1) has real part x0*y0 - x1*y1. Its imaginary part is (x0+x1)*(y0+y1) - x0*y0 - x1*y1, and every value is reduced into [0, p). A simple host port loads and reads RAM words while the block is idle. The surrounding logic uses it to place operands and collect results.

Top module: `fp2_mul_seq`

## Requirements
- R1: The real half of the result equals (x0*y0 - x1*y1) mod p.
- R2: The imaginary half of the result equals ((x0+x1)*(y0+y1) - x0*y0 - x1*y1) mod p.
- R3: Element k occupies RAM word 2k (real half) and word 2k+1 (imaginary half), and the host port addresses those words directly.
- R4: Every written result lies in [0, p), including operands at the extremes 0 and p-1.
- R5: The destination may equal either source or both, and the result is still that of the original operands.
- R6: `done` is high for exactly one cycle, 7 + MUL_LAT clock edges after the edge that accepts the command (10 with the default latency), and `busy` is high in between.
- R7: A command presented while `busy` is high is ignored. It causes no write and no `done`.
- R8: When idle, a host write stores its word, and a host read returns the addressed word on `host_rdata` one cycle later. A host write while `busy` is high is ignored.
- R9: A command changes only the two words of its destination element.
- R10: After reset `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_src_a | input | IDX_W (7) | Index of the first source element |
| cmd_src_b | input | IDX_W (7) | Index of the second source element |
| cmd_dst | input | IDX_W (7) | Index of the destination element |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse after both result halves are written |
| host_we | input | 1 | Host word write strobe (ignored while busy) |
| host_addr | input | IDX_W+1 (8) | Host word address |
| host_wdata | input | W (127) | Host write data |
| host_rdata | output | W (127) | Word read at the previous cycle's host address |

## Verification
Any mis-scheduled step in the sequencer reaches a port on one path only: the two result words read back after `done`. A product captured a cycle early or late, or an operand latched from the wrong RAM port, corrupts one or both halves of that single command's result. Operands at 0, 1 and p-1 and aliased destinations show a wrong fold or a premature write immediately. A broken step counter moves or repeats the `done` pulse, and that shows within the same command's latency window. A leaking busy guard shows up as an overwritten bystander element, which is read back right after the command.

// File: rtl/fp2_pkg.sv
package fp2_pkg;
   // Default base-field width: p = 2^W - 1
   localparam int FP_W_DEF   = 127;
   localparam int IDX_W_DEF  = 7;
   localparam int MUL_LAT_DEF = 3;

   typedef enum logic {
      AS_ADD = 1'b0,
      AS_SUB = 1'b1
   } addsub_op_e;
endpackage

// File: rtl/fp_dpram.sv
module fp_dpram #(
   parameter int W  = 127,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we_a,
   input  logic [AW-1:0] addr_a,
   input  logic [W-1:0]  wd_a,
   output logic [W-1:0]  rd_a,
   input  logic          we_b,
   input  logic [AW-1:0] addr_b,
   input  logic [W-1:0]  wd_b,
   output logic [W-1:0]  rd_b
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] mem [DEPTH];

   initial begin
      assert (AW >= 1) else $error("fp_dpram: AW must be at least 1");
   end

   // Read-first on both ports; the two ports never write one word together
   always_ff @(posedge clk) begin
      if (we_a) mem[addr_a] <= wd_a;
      if (we_b) mem[addr_b] <= wd_b;
      rd_a <= mem[addr_a];
      rd_b <= mem[addr_b];
   end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
   import fp2_pkg::*;
#(
   parameter int W = 127
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  addsub_op_e   op,
   output logic [W-1:0] r
);
   localparam logic [W-1:0] P = {W{1'b1}};

   logic [W:0]   sum_w;
   logic [W-1:0] sum_f;
   logic [W:0]   dif_w;
   logic [W-1:0] dif_f;

   initial begin
      assert (W >= 2) else $error("fp_addsub: W must be at least 2");
   end

   always_comb begin
      // Sum: fold the carry back in, since 2^W == 1 (mod p)
      sum_w = {1'b0, x} + {1'b0, y};
      sum_f = sum_w[W-1:0] + {{(W-1){1'b0}}, sum_w[W]};
      if (sum_f == P) sum_f = '0;
      // Difference: on borrow add p, i.e. subtract one more mod 2^W
      dif_w = {1'b0, x} - {1'b0, y};
      dif_f = dif_w[W] ? (dif_w[W-1:0] - {{(W-1){1'b0}}, 1'b1}) : dif_w[W-1:0];
      r = (op == AS_SUB) ? dif_f : sum_f;
   end
endmodule

// File: rtl/fp_mulpipe.sv
module fp_mulpipe #(
   parameter int W   = 127,
   parameter int LAT = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic         out_valid,
   output logic [W-1:0] out
);
   localparam logic [W-1:0] P = {W{1'b1}};

   logic [LAT-1:0] vld;

   initial begin
      assert (LAT >= 1) else $error("fp_mulpipe: LAT must be at least 1");
   end

   function automatic logic [W-1:0] fold(input logic [2*W-1:0] prod);
      logic [W:0]   t;
      logic [W-1:0] u;
      t = {1'b0, prod[W-1:0]} + {1'b0, prod[2*W-1:W]};
      u = t[W-1:0] + {{(W-1){1'b0}}, t[W]};
      return (u == P) ? '0 : u;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) vld <= '0;
      else     vld <= {vld[LAT-1:0] << 1} | {{(LAT-1){1'b0}}, in_valid};
   end
   assign out_valid = vld[LAT-1];

   generate
      if (LAT == 1) begin : g_single
         // Multiply and fold in one stage
         always_ff @(posedge clk) out <= fold(x * y);
      end else begin : g_split
         // Raw product registered first, fold in the second stage
         logic [2*W-1:0] raw_q;
         logic [W-1:0]   dly [LAT-1];
         always_ff @(posedge clk) begin
            raw_q  <= {{W{1'b0}}, x} * {{W{1'b0}}, y};
            dly[0] <= fold(raw_q);
         end
         for (genvar i = 1; i < LAT - 1; i++) begin : g_dly
            always_ff @(posedge clk) dly[i] <= dly[i-1];
         end
         assign out = dly[LAT-2];
      end
   endgenerate

   AST_MUL_CANON: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out < P)); // R4
endmodule

// File: rtl/fp2_mul_seq.sv
module fp2_mul_seq
   import fp2_pkg::*;
#(
   parameter int W       = FP_W_DEF,
   parameter int IDX_W   = IDX_W_DEF,
   parameter int MUL_LAT = MUL_LAT_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_valid,
   input  logic [IDX_W-1:0] cmd_src_a,
   input  logic [IDX_W-1:0] cmd_src_b,
   input  logic [IDX_W-1:0] cmd_dst,
   output logic             busy,
   output logic             done,
   input  logic             host_we,
   input  logic [IDX_W:0]   host_addr,
   input  logic [W-1:0]     host_wdata,
   output logic [W-1:0]     host_rdata
);
   localparam int AW = IDX_W + 1;
   localparam logic [W-1:0] P = {W{1'b1}};
   // Schedule: 0 read x, 1 read y, 2 sum x, 3 sum y + issue x0*y0,
   // 4 issue x1*y1, 5 issue sx*sy, then three subtractions, last step writes
   localparam int LAST = 6 + MUL_LAT;
   localparam int STW  = $clog2(LAST + 1);
   localparam logic [STW-1:0] S_RDX  = STW'(0);
   localparam logic [STW-1:0] S_RDY  = STW'(1);
   localparam logic [STW-1:0] S_SUMX = STW'(2);
   localparam logic [STW-1:0] S_SUMY = STW'(3);
   localparam logic [STW-1:0] S_M1   = STW'(4);
   localparam logic [STW-1:0] S_M2   = STW'(5);
   localparam logic [STW-1:0] S_P0   = STW'(3 + MUL_LAT);
   localparam logic [STW-1:0] S_RE   = STW'(4 + MUL_LAT);
   localparam logic [STW-1:0] S_U    = STW'(5 + MUL_LAT);
   localparam logic [STW-1:0] S_WB   = STW'(LAST);

   initial begin
      assert (IDX_W >= 1) else $error("fp2_mul_seq: IDX_W must be at least 1");
      assert (MUL_LAT >= 1) else $error("fp2_mul_seq: MUL_LAT must be at least 1");
   end

   logic [STW-1:0]   step;
   logic [IDX_W-1:0] sa_q, sb_q, dst_q;
   logic [W-1:0]     x0, x1, y0, y1, sx, sy, p0, p1, re_q, u_q;
   logic             accept;

   // RAM port wiring
   logic          we_a, we_b;
   logic [AW-1:0] addr_a, addr_b;
   logic [W-1:0]  wd_a, wd_b, rd_a, rd_b;

   // Arithmetic units
   logic [W-1:0] as_x, as_y, as_r;
   addsub_op_e   as_op;
   logic         mul_iv, mul_ov;
   logic [W-1:0] mul_x, mul_y, mul_out;

   assign accept = cmd_valid && !busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         done <= 1'b0;
         step <= '0;
      end else begin
         done <= busy && (step == S_WB);
         if (accept) begin
            busy <= 1'b1;
            step <= '0;
         end else if (busy) begin
            if (step == S_WB) busy <= 1'b0;
            else              step <= step + STW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         sa_q  <= cmd_src_a;
         sb_q  <= cmd_src_b;
         dst_q <= cmd_dst;
      end
   end

   // Port A carries the real halves, port B the imaginary halves
   always_comb begin
      addr_a = host_addr;
      addr_b = host_addr;
      we_a   = host_we;
      we_b   = 1'b0;
      wd_a   = host_wdata;
      wd_b   = as_r;
      if (busy) begin
         we_a = 1'b0;
         wd_a = re_q;
         unique case (step)
            S_RDX: begin
               addr_a = {sa_q, 1'b0};
               addr_b = {sa_q, 1'b1};
            end
            S_RDY: begin
               addr_a = {sb_q, 1'b0};
               addr_b = {sb_q, 1'b1};
            end
            S_WB: begin
               addr_a = {dst_q, 1'b0};
               addr_b = {dst_q, 1'b1};
               we_a   = 1'b1;
               we_b   = 1'b1;
            end
            default: ;
         endcase
      end
   end

   fp_dpram #(.W(W), .AW(AW)) u_ram (
      .clk(clk),
      .we_a(we_a), .addr_a(addr_a), .wd_a(wd_a), .rd_a(rd_a),
      .we_b(we_b), .addr_b(addr_b), .wd_b(wd_b), .rd_b(rd_b)
   );
   assign host_rdata = rd_b;

   // Shared modular adder: two sums, three differences
   always_comb begin
      as_x  = x0;
      as_y  = x1;
      as_op = AS_ADD;
      unique case (step)
         S_SUMY: begin as_x = y0;   as_y = y1; end
         S_RE:   begin as_x = p0;   as_y = mul_out; as_op = AS_SUB; end
         S_U:    begin as_x = mul_out; as_y = p0;   as_op = AS_SUB; end
         S_WB:   begin as_x = u_q;  as_y = p1;      as_op = AS_SUB; end
         default: ;
      endcase
   end

   fp_addsub #(.W(W)) u_addsub (
      .x(as_x), .y(as_y), .op(as_op), .r(as_r)
   );

   // Three products issued on consecutive cycles
   always_comb begin
      mul_iv = busy && (step == S_SUMY || step == S_M1 || step == S_M2);
      mul_x  = x0;
      mul_y  = y0;
      if (step == S_M1) begin
         mul_x = x1;
         mul_y = y1;
      end else if (step == S_M2) begin
         mul_x = sx;
         mul_y = sy;
      end
   end

   fp_mulpipe #(.W(W), .LAT(MUL_LAT)) u_mul (
      .clk(clk), .rst(rst),
      .in_valid(mul_iv), .x(mul_x), .y(mul_y),
      .out_valid(mul_ov), .out(mul_out)
   );

   // Operand and intermediate capture
   always_ff @(posedge clk) begin
      if (busy) begin
         if (step == S_RDY) begin
            x0 <= rd_a;
            x1 <= rd_b;
         end
         if (step == S_SUMX) begin
            y0 <= rd_a;
            y1 <= rd_b;
            sx <= as_r;
         end
         if (step == S_SUMY) sy <= as_r;
         if (step == S_P0)   p0 <= mul_out;
         if (step == S_RE) begin
            p1   <= mul_out;
            re_q <= as_r;
         end
         if (step == S_U)    u_q <= as_r;
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R6
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(busy) && !busy)); // R6
   AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
      busy |=> ($stable(dst_q) && $stable(sa_q) && $stable(sb_q))); // R7
   AST_PRODUCT_ARRIVES: assert property (@(posedge clk) disable iff (rst)
      (busy && (step == S_P0)) |-> mul_ov); // R1
   AST_WB_CANON: assert property (@(posedge clk) disable iff (rst)
      (busy && (step == S_WB)) |-> ((wd_a < P) && (wd_b < P))); // R4
endmodule

// File: tb/tb_fp2_mul_seq.sv
module tb_fp2_mul_seq;
   localparam int W = 127;
   localparam int IDX_W = 7;
   localparam int MUL_LAT = 3;
   localparam int LATENCY = 7 + MUL_LAT;
   localparam logic [W-1:0] P = {W{1'b1}};

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             cmd_valid = 1'b0;
   logic [IDX_W-1:0] cmd_src_a = '0, cmd_src_b = '0, cmd_dst = '0;
   logic             busy, done;
   logic             host_we = 1'b0;
   logic [IDX_W:0]   host_addr = '0;
   logic [W-1:0]     host_wdata = '0;
   logic [W-1:0]     host_rdata;

   always #5 clk = ~clk;

   fp2_mul_seq #(.W(W), .IDX_W(IDX_W), .MUL_LAT(MUL_LAT)) dut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
      .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst),
      .busy(busy), .done(done),
      .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   int checks = 0;
   int fails  = 0;

   typedef struct {
      int           dst;
      logic [W-1:0] re;
      logic [W-1:0] im;
   } exp_t;
   exp_t sb_q[$];

   logic [W-1:0] m_re [128];
   logic [W-1:0] m_im [128];

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] f_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [2*W-1:0] pr;
      pr = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      pr = pr % {{W{1'b0}}, P};
      return pr[W-1:0];
   endfunction

   function automatic logic [W-1:0] f_add(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0] s;
      s = ({1'b0, a} + {1'b0, b}) % {1'b0, P};
      return s[W-1:0];
   endfunction

   function automatic logic [W-1:0] f_sub(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0] s;
      s = ({1'b0, a} + {1'b0, P} - {1'b0, b}) % {1'b0, P};
      return s[W-1:0];
   endfunction

   function automatic logic [W-1:0] rnd();
      logic [127:0] v;
      v = {$urandom(), $urandom(), $urandom(), $urandom()};
      return (v[W-1:0] == P) ? '0 : v[W-1:0];
   endfunction

   task automatic host_write(input int addr, input logic [W-1:0] data);
      @(negedge clk);
      host_we = 1'b1;
      host_addr = (IDX_W+1)'(addr);
      host_wdata = data;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_read(input int addr, output logic [W-1:0] data);
      @(negedge clk);
      host_addr = (IDX_W+1)'(addr);
      @(negedge clk);
      data = host_rdata;
   endtask

   task automatic put_elem(input int k, input logic [W-1:0] re, input logic [W-1:0] im);
      host_write(2*k, re);     // R3: real half at word 2k
      host_write(2*k + 1, im); // R3: imaginary half at word 2k+1
      m_re[k] = re;
      m_im[k] = im;
   endtask

   task automatic check_elem(input int k, input string req);
      logic [W-1:0] v;
      host_read(2*k, v);
      chk(v == m_re[k], req, v, m_re[k]);
      host_read(2*k + 1, v);
      chk(v == m_im[k], req, v, m_im[k]);
   endtask

   // Driver: push the expected result, issue the command, time done
   task automatic run_cmd(input int a, input int b, input int d, input bit poke);
      exp_t e;
      logic [W-1:0] t0, t1, t2;
      int n;
      t0 = f_mul(m_re[a], m_re[b]);
      t1 = f_mul(m_im[a], m_im[b]);
      t2 = f_mul(f_add(m_re[a], m_im[a]), f_add(m_re[b], m_im[b]));
      e.dst = d;
      e.re = f_sub(t0, t1);
      e.im = f_sub(f_sub(t2, t0), t1);
      sb_q.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_src_a = IDX_W'(a);
      cmd_src_b = IDX_W'(b);
      cmd_dst   = IDX_W'(d);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b1, "R6 busy after accept", W'(busy), W'(1));
      n = 0;
      forever begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (poke && n == 3) begin
            // R7/R8: command and host write while busy
            cmd_valid = 1'b1;
            cmd_src_a = IDX_W'(1);
            cmd_src_b = IDX_W'(1);
            cmd_dst   = IDX_W'(30);
            host_we   = 1'b1;
            host_addr = (IDX_W+1)'(2*31);
            host_wdata = W'(5);
         end
         if (poke && n == 4) begin
            cmd_valid = 1'b0;
            host_we   = 1'b0;
         end
         if (done) break;
         if (n > 200) break;
      end
      chk(n == LATENCY, "R6 done latency", W'(n), W'(LATENCY));
      chk(busy == 1'b0, "R6 busy low at done", W'(busy), W'(0));
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", W'(done), W'(0));
      m_re[d] = e.re;
      m_im[d] = e.im;
   endtask

   // Monitor side of the scoreboard: pop and compare the written element
   task automatic drain(input string req);
      exp_t e;
      logic [W-1:0] v;
      while (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         host_read(2*e.dst, v);
         chk(v == e.re, {req, " R1 real half"}, v, e.re);
         host_read(2*e.dst + 1, v);
         chk(v == e.im, {req, " R2 imaginary half"}, v, e.im);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [W-1:0] v;
      bit again;
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R10 busy in reset", W'(busy), W'(0));
      chk(done == 1'b0, "R10 done in reset", W'(done), W'(0));
      rst = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R10 idle after reset", W'({busy, done}), W'(0));

      put_elem(0, '0, '0);
      put_elem(1, P - W'(1), P - W'(1));
      put_elem(2, W'(1), '0);
      put_elem(3, '0, W'(1));
      for (int k = 4; k < 10; k++) put_elem(k, rnd(), rnd());
      put_elem(10, {1'b1, {(W-1){1'b0}}} >> 0, P - W'(1));
      put_elem(19, W'(123), W'(456));
      put_elem(25, rnd(), rnd());
      put_elem(30, W'(9), W'(10));
      put_elem(31, W'(7), W'(8));
      // R8: idle host write then read back with one-cycle latency
      host_read(2*19, v);
      chk(v == W'(123), "R8 host readback", v, W'(123));
      check_elem(25, "R3 element layout");

      run_cmd(1, 1, 20, 1'b0);   // R4: (p-1) extremes
      drain("R4 extremes");
      run_cmd(4, 5, 21, 1'b0);
      run_cmd(2, 3, 23, 1'b0);   // one times i
      run_cmd(0, 4, 24, 1'b0);   // zero operand
      drain("random/unit/zero");

      run_cmd(6, 7, 22, 1'b1);   // with pokes while busy
      drain("poked");
      again = 1'b0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (done || busy) again = 1'b1;
      end
      chk(again == 1'b0, "R7 no second command", W'(again), W'(0));
      check_elem(30, "R7 ignored destination untouched");
      check_elem(31, "R8 host write while busy ignored");

      run_cmd(8, 8, 8, 1'b0);    // R5: full alias, squaring in place
      drain("R5 full alias");
      run_cmd(9, 10, 9, 1'b0);   // R5: destination equals first source
      drain("R5 alias src a");
      run_cmd(10, 5, 5, 1'b0);   // R5: destination equals second source
      drain("R5 alias src b");

      check_elem(19, "R9 bystander below");
      check_elem(25, "R9 bystander above");
      check_elem(4, "R9 source kept");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule